// File: doc/BRIEF.md
# Parallel Video Capture Front-End

This block sits between a raw parallel camera bus and the rest of a capture pipeline. It watches the source's pixel clock, data lines, line sync, frame sync and field wire. It turns them into one normalized stream: a one-cycle valid strobe, a right-aligned pixel, a line-start flag, a frame-start flag and a field flag. Every electrical convention of the link is chosen at run time by configuration inputs:
- the window of data lines that carries the pixel, and the data polarity;
- the level of each sync and of the field wire;
- the pixel-clock edge that samples the bus;
- where timing comes from: discrete sync wires, sync codes embedded in the data, or a sync generator inside the block that drives the source.

The block runs on a system clock that is faster than the pixel clock. The pixel clock, data and syncs are registered in the system clock domain, and the chosen edge of the registered pixel clock marks each sample. The configuration inputs are copied into an active set only at a frame boundary, so no frame is captured under a mix of settings. Embedded codes are read from the eight least significant bits of the extracted pixel, so `OUT_W` must be at least 8.

Top module: `vcap_front`

## Requirements
- R1: Each sample's pixel is the bus shifted right by `cfg_shift`, keeping the low `cfg_width` bits (widths above `OUT_W` keep all `OUT_W` bits), with the upper output bits zero.
- R2: When `cfg_dat_pol` is 0 the bus bits are inverted before extraction; when it is 1 they are used as they are.
- R3: A sample is taken on the rising pixel-clock edge when `cfg_edge_rise` is 1 and on the falling edge when it is 0. A valid sample raises `pix_valid` for exactly one system clock, on the second system clock edge after the pixel-clock transition is at the input.
- R4: In discrete mode a sync is active when its input level equals its polarity bit (1 high, 0 low), with the line and frame polarities set independently. A sample is valid only when both syncs are inactive.
- R5: `pix_frame_start` marks the first valid sample after the leading edge of the active frame sync (or the frame boundary of the selected timing source). `pix_line_start` marks the first valid sample after any sample taken with the line sync active (or after an embedded start code).
- R6: In discrete mode `pix_field` is 0 when the field input equals `cfg_fld_even` (even field) and 1 otherwise.
- R7: With `cfg_embedded` set, a run of codes FF, 00, 00 introduces a status word whose bit 6 is the field, bit 5 is blanking and bit 4 is 1 for end and 0 for start of video. Only a start word with blanking 0 opens active video. An end word or an FF word closes it. Code words are never output. A blanking bit that goes from 0 to 1 is the frame boundary, and `pix_field` is the inverse of bit 6.
- R8: With `cfg_slave` set (it overrides `cfg_embedded`), the block counts samples over `cfg_htot` per line and `cfg_vtot` lines per frame. It drives `gen_hs` active for the first `cfg_hsw` samples of a line and `gen_vs` for the first `cfg_vsw` lines, each at its polarity, and ignores `vid_hs`/`vid_vs`. Out of slave mode both outputs hold their inactive level.
- R9: Configuration inputs are copied into the active set at reset and at each frame boundary. Samples before the boundary use the old set and samples after it use the new one.
- R10: After reset `pix_valid`, `pix_line_start` and `pix_frame_start` are 0, and the generated syncs are at the level R8 gives for counters at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | 4 | Number of data lines used |
| cfg_shift | input | 4 | Lowest data line used |
| cfg_hs_pol | input | 1 | Line sync active level |
| cfg_vs_pol | input | 1 | Frame sync active level |
| cfg_dat_pol | input | 1 | Data polarity, 0 inverts |
| cfg_fld_even | input | 1 | Field wire level in the even field |
| cfg_edge_rise | input | 1 | 1 samples on rising, 0 on falling pixel clock |
| cfg_embedded | input | 1 | Take timing from embedded codes |
| cfg_slave | input | 1 | Generate syncs inside the block |
| cfg_htot | input | 12 | Samples per generated line |
| cfg_hsw | input | 12 | Generated line sync width in samples |
| cfg_vtot | input | 11 | Lines per generated frame |
| cfg_vsw | input | 11 | Generated frame sync width in lines |
| vid_pclk | input | 1 | Source pixel clock |
| vid_data | input | IN_W | Source data lines |
| vid_hs | input | 1 | Source line sync |
| vid_vs | input | 1 | Source frame sync |
| vid_field | input | 1 | Source field wire |
| gen_hs | output | 1 | Generated line sync to the source |
| gen_vs | output | 1 | Generated frame sync to the source |
| pix_valid | output | 1 | One-cycle sample strobe |
| pix_data | output | OUT_W | Extracted pixel |
| pix_line_start | output | 1 | First sample of a line |
| pix_frame_start | output | 1 | First sample of a frame |
| pix_field | output | 1 | 1 odd field, 0 even field |

## Verification
Two functions meet on the frame sync's leading edge: the configuration reload and the change of sampling edge, data polarity and sync polarities that the reload brings. The bench changes every configuration input in the middle of a frame. A pixel before the boundary must still come out under the old window and polarity, and the first pixel after it must be sampled on the new edge and carry both the frame-start and line-start flags. A second meeting happens in slave mode, where the generator's wrap to the first line and sample both opens a frame and asserts both generated syncs in the same sample. The bench's own model predicts both syncs and the flags there on every clock.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

    parameter int HCNT_W = 12;
    parameter int VCNT_W = 11;
    parameter int SEL_W  = 4;

    localparam int          CODE_W    = 8;
    localparam logic [CODE_W-1:0] CODE_ALL1 = '1;
    localparam logic [CODE_W-1:0] CODE_ALL0 = '0;
    localparam int          XY_F_BIT  = 6;
    localparam int          XY_V_BIT  = 5;
    localparam int          XY_H_BIT  = 4;

    typedef struct packed {
        logic [SEL_W-1:0]  width;
        logic [SEL_W-1:0]  shift;
        logic              hs_pol;
        logic              vs_pol;
        logic              dat_pol;
        logic              fld_even;
        logic              edge_rise;
        logic              embedded;
        logic              slave;
        logic [HCNT_W-1:0] htot;
        logic [HCNT_W-1:0] hsw;
        logic [VCNT_W-1:0] vtot;
        logic [VCNT_W-1:0] vsw;
    } vcap_cfg_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ONE  = 2'd1,
        SEQ_TWO  = 2'd2,
        SEQ_XY   = 2'd3
    } code_seq_e;

    // active-high view of a wire given its active level
    function automatic logic sync_on(input logic level, input logic pol);
        return level == pol;
    endfunction

    // wire level that expresses an active-high flag at a given polarity
    function automatic logic sync_drive(input logic on, input logic pol);
        return on ? pol : ~pol;
    endfunction

endpackage

// File: rtl/vcap_shadow.sv
module vcap_shadow
    import vcap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      apply,
    input  vcap_cfg_t cfg_in,
    output vcap_cfg_t cfg_act
);

    always_ff @(posedge clk) begin
        if (rst || apply) begin
            cfg_act <= cfg_in;
        end
    end

endmodule

// File: rtl/vcap_extract.sv
module vcap_extract
    import vcap_pkg::*;
#(
    parameter int IN_W  = 12,
    parameter int OUT_W = 10
) (
    input  logic [IN_W-1:0]  bus,
    input  logic             dat_pol,
    input  logic [SEL_W-1:0] shift,
    input  logic [SEL_W-1:0] width,
    output logic [OUT_W-1:0] pix
);

    logic [IN_W-1:0] norm_bus;
    logic [IN_W-1:0] shifted;

    assign norm_bus = dat_pol ? bus : ~bus;
    assign shifted  = norm_bus >> shift;

    for (genvar i = 0; i < OUT_W; i++) begin : g_bit
        if (i < IN_W) begin : g_lane
            assign pix[i] = (i < int'(width)) ? shifted[i] : 1'b0;
        end else begin : g_pad
            assign pix[i] = 1'b0;
        end
    end

endmodule

// File: rtl/vcap_embed.sv
module vcap_embed
    import vcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              en,
    input  logic [CODE_W-1:0] word,
    output logic              pix_ok,
    output logic              sav_open,
    output logic              frame_edge,
    output logic              field_odd
);

    code_seq_e seq;
    logic      in_video;
    logic      last_v;
    logic      is_xy;
    logic      xy_v;
    logic      xy_h;

    assign is_xy      = (seq == SEQ_XY);
    assign xy_v       = word[XY_V_BIT];
    assign xy_h       = word[XY_H_BIT];
    assign pix_ok     = in_video && (seq == SEQ_IDLE) && (word != CODE_ALL1);
    assign sav_open   = is_xy && !xy_h && !xy_v;
    assign frame_edge = is_xy && xy_v && !last_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            seq       <= SEQ_IDLE;
            in_video  <= 1'b0;
            last_v    <= 1'b0;
            field_odd <= 1'b0;
        end else if (tick) begin
            if (!en) begin
                seq      <= SEQ_IDLE;
                in_video <= 1'b0;
            end else if (is_xy) begin
                seq       <= SEQ_IDLE;
                in_video  <= sav_open;
                last_v    <= xy_v;
                field_odd <= ~word[XY_F_BIT];
            end else if (word == CODE_ALL1) begin
                seq      <= SEQ_ONE;
                in_video <= 1'b0;
            end else if (seq == SEQ_ONE && word == CODE_ALL0) begin
                seq <= SEQ_TWO;
            end else if (seq == SEQ_TWO && word == CODE_ALL0) begin
                seq <= SEQ_XY;
            end else begin
                seq <= SEQ_IDLE;
            end
        end
    end

endmodule

// File: rtl/vcap_syncgen.sv
module vcap_syncgen
    import vcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              en,
    input  logic [HCNT_W-1:0] htot,
    input  logic [HCNT_W-1:0] hsw,
    input  logic [VCNT_W-1:0] vtot,
    input  logic [VCNT_W-1:0] vsw,
    output logic              hs_on,
    output logic              vs_on
);

    logic [HCNT_W-1:0] hcnt;
    logic [VCNT_W-1:0] vcnt;
    logic              h_last;
    logic              v_last;

    assign h_last = (hcnt == htot - 1'b1);
    assign v_last = (vcnt == vtot - 1'b1);
    assign hs_on  = (hcnt < hsw);
    assign vs_on  = (vcnt < vsw);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (tick) begin
            if (h_last) begin
                hcnt <= '0;
                vcnt <= v_last ? '0 : vcnt + 1'b1;
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/vcap_front.sv
module vcap_front
    import vcap_pkg::*;
#(
    parameter int IN_W  = 12,
    parameter int OUT_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  cfg_width,
    input  logic [SEL_W-1:0]  cfg_shift,
    input  logic              cfg_hs_pol,
    input  logic              cfg_vs_pol,
    input  logic              cfg_dat_pol,
    input  logic              cfg_fld_even,
    input  logic              cfg_edge_rise,
    input  logic              cfg_embedded,
    input  logic              cfg_slave,
    input  logic [HCNT_W-1:0] cfg_htot,
    input  logic [HCNT_W-1:0] cfg_hsw,
    input  logic [VCNT_W-1:0] cfg_vtot,
    input  logic [VCNT_W-1:0] cfg_vsw,
    input  logic              vid_pclk,
    input  logic [IN_W-1:0]   vid_data,
    input  logic              vid_hs,
    input  logic              vid_vs,
    input  logic              vid_field,
    output logic              gen_hs,
    output logic              gen_vs,
    output logic              pix_valid,
    output logic [OUT_W-1:0]  pix_data,
    output logic              pix_line_start,
    output logic              pix_frame_start,
    output logic              pix_field
);

    vcap_cfg_t cfg_req;
    vcap_cfg_t cfg_act;

    logic            pclk_q, pclk_q2;
    logic [IN_W-1:0] data_q;
    logic            hs_q, vs_q, fld_q;
    logic            tick;

    logic [OUT_W-1:0]  pix;
    logic [CODE_W-1:0] code_w;
    logic              e_pix, e_sav, e_bnd, e_fld;
    logic              g_hs_on, g_vs_on;

    logic emb_mode;
    logic hs_n, vs_n, vs_prev;
    logic frame_bnd, valid_now, line_set;
    logic frame_pend, line_pend;

    assign cfg_req = '{
        width:     cfg_width,
        shift:     cfg_shift,
        hs_pol:    cfg_hs_pol,
        vs_pol:    cfg_vs_pol,
        dat_pol:   cfg_dat_pol,
        fld_even:  cfg_fld_even,
        edge_rise: cfg_edge_rise,
        embedded:  cfg_embedded,
        slave:     cfg_slave,
        htot:      cfg_htot,
        hsw:       cfg_hsw,
        vtot:      cfg_vtot,
        vsw:       cfg_vsw
    };

    // input capture in the system clock domain
    always_ff @(posedge clk) begin
        pclk_q  <= vid_pclk;
        pclk_q2 <= pclk_q;
        data_q  <= vid_data;
        hs_q    <= vid_hs;
        vs_q    <= vid_vs;
        fld_q   <= vid_field;
    end

    assign tick = cfg_act.edge_rise ? (pclk_q & ~pclk_q2) : (~pclk_q & pclk_q2);

    vcap_shadow u_shadow (
        .clk     (clk),
        .rst     (rst),
        .apply   (frame_bnd),
        .cfg_in  (cfg_req),
        .cfg_act (cfg_act)
    );

    vcap_extract #(.IN_W(IN_W), .OUT_W(OUT_W)) u_extract (
        .bus     (data_q),
        .dat_pol (cfg_act.dat_pol),
        .shift   (cfg_act.shift),
        .width   (cfg_act.width),
        .pix     (pix)
    );

    assign code_w   = pix[CODE_W-1:0];
    assign emb_mode = cfg_act.embedded & ~cfg_act.slave;

    vcap_embed u_embed (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .en         (emb_mode),
        .word       (code_w),
        .pix_ok     (e_pix),
        .sav_open   (e_sav),
        .frame_edge (e_bnd),
        .field_odd  (e_fld)
    );

    vcap_syncgen u_syncgen (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .en    (cfg_act.slave),
        .htot  (cfg_act.htot),
        .hsw   (cfg_act.hsw),
        .vtot  (cfg_act.vtot),
        .vsw   (cfg_act.vsw),
        .hs_on (g_hs_on),
        .vs_on (g_vs_on)
    );

    assign hs_n = cfg_act.slave ? g_hs_on : sync_on(hs_q, cfg_act.hs_pol);
    assign vs_n = cfg_act.slave ? g_vs_on : sync_on(vs_q, cfg_act.vs_pol);

    assign frame_bnd = tick & (emb_mode ? e_bnd : (vs_n & ~vs_prev));
    assign valid_now = tick & (emb_mode ? e_pix : (~hs_n & ~vs_n));
    assign line_set  = tick & (emb_mode ? e_sav : hs_n);

    assign gen_hs = sync_drive(cfg_act.slave & g_hs_on, cfg_act.hs_pol);
    assign gen_vs = sync_drive(cfg_act.slave & g_vs_on, cfg_act.vs_pol);

    always_ff @(posedge clk) begin
        if (rst) begin
            vs_prev         <= 1'b0;
            frame_pend      <= 1'b0;
            line_pend       <= 1'b0;
            pix_valid       <= 1'b0;
            pix_data        <= '0;
            pix_line_start  <= 1'b0;
            pix_frame_start <= 1'b0;
            pix_field       <= 1'b0;
        end else begin
            if (tick && !emb_mode) begin
                vs_prev <= vs_n;
            end
            if (frame_bnd) begin
                frame_pend <= 1'b1;
            end else if (valid_now) begin
                frame_pend <= 1'b0;
            end
            if (line_set) begin
                line_pend <= 1'b1;
            end else if (valid_now) begin
                line_pend <= 1'b0;
            end
            pix_valid       <= valid_now;
            pix_line_start  <= valid_now & line_pend;
            pix_frame_start <= valid_now & frame_pend;
            if (valid_now) begin
                pix_data  <= pix;
                pix_field <= emb_mode ? e_fld : (fld_q != cfg_act.fld_even);
            end
        end
    end

endmodule

// File: rtl/vcap_front_chk.sv
module vcap_front_chk
    import vcap_pkg::*;
#(
    parameter int OUT_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             pix_valid,
    input logic             pix_line_start,
    input logic             pix_frame_start,
    input logic [OUT_W-1:0] pix_data,
    input logic             apply,
    input vcap_cfg_t        act_cfg
);

    AST_FRAME_FLAG_VALID: assert property (@(posedge clk) disable iff (rst)
        pix_frame_start |-> pix_valid);                               // R5

    AST_LINE_FLAG_VALID: assert property (@(posedge clk) disable iff (rst)
        pix_line_start |-> pix_valid);                                // R5

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> !pix_valid);                                    // R3

    AST_DATA_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> ((pix_data >> act_cfg.width) == '0));           // R1

    AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(apply)) |-> $stable(act_cfg));         // R9

endmodule

bind vcap_front vcap_front_chk #(.OUT_W(OUT_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .pix_valid       (pix_valid),
    .pix_line_start  (pix_line_start),
    .pix_frame_start (pix_frame_start),
    .pix_data        (pix_data),
    .apply           (frame_bnd),
    .act_cfg         (cfg_act)
);

// File: tb/sim_vcap_front.sv
module sim_vcap_front;

    localparam int CLK_PERIOD = 10;
    localparam int IN_W  = 12;
    localparam int OUT_W = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0]  cfg_width = 4'd8, cfg_shift = 4'd2;
    logic cfg_hs_pol = 0, cfg_vs_pol = 1, cfg_dat_pol = 1, cfg_fld_even = 1;
    logic cfg_edge_rise = 1, cfg_embedded = 0, cfg_slave = 0;
    logic [11:0] cfg_htot = 12'd6, cfg_hsw = 12'd1;
    logic [10:0] cfg_vtot = 11'd4, cfg_vsw = 11'd1;
    logic pclk = 1'b0;
    logic [IN_W-1:0] vdata = '0;
    logic vhs = 1'b1, vvs = 1'b0, vfld = 1'b0;
    logic gen_hs, gen_vs, pix_valid, pix_line_start, pix_frame_start, pix_field;
    logic [OUT_W-1:0] pix_data;

    int checks = 0;
    int fails  = 0;
    string ph = "R10 reset";

    always #(CLK_PERIOD/2) clk = ~clk;

    vcap_front #(.IN_W(IN_W), .OUT_W(OUT_W)) u0 (
        .clk(clk), .rst(rst),
        .cfg_width(cfg_width), .cfg_shift(cfg_shift),
        .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol),
        .cfg_dat_pol(cfg_dat_pol), .cfg_fld_even(cfg_fld_even),
        .cfg_edge_rise(cfg_edge_rise), .cfg_embedded(cfg_embedded),
        .cfg_slave(cfg_slave), .cfg_htot(cfg_htot), .cfg_hsw(cfg_hsw),
        .cfg_vtot(cfg_vtot), .cfg_vsw(cfg_vsw),
        .vid_pclk(pclk), .vid_data(vdata), .vid_hs(vhs), .vid_vs(vvs),
        .vid_field(vfld), .gen_hs(gen_hs), .gen_vs(gen_vs),
        .pix_valid(pix_valid), .pix_data(pix_data),
        .pix_line_start(pix_line_start), .pix_frame_start(pix_frame_start),
        .pix_field(pix_field)
    );

    // behavioural reference state
    int m_w, m_sh, m_htot, m_hsw, m_vtot, m_vsw, m_h, m_v, m_seq;
    bit m_hp, m_vp, m_dp, m_fe, m_edge, m_emb, m_slv;
    bit m_vsprev, m_fpend, m_lpend, m_active, m_lastv, m_efield;
    bit e_valid, e_ls, e_fs, e_fld;
    logic [OUT_W-1:0] e_data;

    task automatic load_cfg();
        m_w = cfg_width; m_sh = cfg_shift; m_hp = cfg_hs_pol; m_vp = cfg_vs_pol;
        m_dp = cfg_dat_pol; m_fe = cfg_fld_even; m_edge = cfg_edge_rise;
        m_emb = cfg_embedded; m_slv = cfg_slave;
        m_htot = cfg_htot; m_hsw = cfg_hsw; m_vtot = cfg_vtot; m_vsw = cfg_vsw;
    endtask

    function automatic bit exp_ghs();
        return (m_slv && m_h < m_hsw) ? m_hp : !m_hp;
    endfunction
    function automatic bit exp_gvs();
        return (m_slv && m_v < m_vsw) ? m_vp : !m_vp;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s (%s) at %0t: got %0h expected %0h", tag, ph, $time, got, exp);
        end
    endtask

    task automatic cmp();
        @(negedge clk);
        chk("R3 pix_valid", 32'(pix_valid), 32'(e_valid));
        if (e_valid) begin
            chk("R1 pix_data", 32'(pix_data), 32'(e_data));
            chk("R5 line_start", 32'(pix_line_start), 32'(e_ls));
            chk("R5 frame_start", 32'(pix_frame_start), 32'(e_fs));
            chk("R6 field", 32'(pix_field), 32'(e_fld));
        end
        chk("R8 gen_hs", 32'(gen_hs), 32'(exp_ghs()));
        chk("R8 gen_vs", 32'(gen_vs), 32'(exp_gvs()));
    endtask

    task automatic model_tick(input logic [IN_W-1:0] d, input bit h, input bit v, input bit f);
        logic [IN_W-1:0] b;
        logic [OUT_W-1:0] px;
        bit ok, bnd, lset, hn, vn, fo;
        b = m_dp ? d : ~d;
        px = '0;
        for (int i = 0; i < OUT_W; i++)
            if (i < m_w && i + m_sh < IN_W) px[i] = b[i + m_sh];
        ok = 0; bnd = 0; lset = 0; fo = 0;
        if (m_emb && !m_slv) begin
            if (m_seq == 3) begin
                m_seq = 0;
                m_active = !px[4] && !px[5];
                lset = m_active;
                bnd = px[5] && !m_lastv;
                m_lastv = px[5];
                m_efield = !px[6];
            end else if (px[7:0] == 8'hFF) begin
                m_seq = 1; m_active = 0;
            end else if (m_seq == 1 && px[7:0] == 8'h00) begin
                m_seq = 2;
            end else if (m_seq == 2 && px[7:0] == 8'h00) begin
                m_seq = 3;
            end else begin
                ok = m_active && m_seq == 0;
                m_seq = 0;
            end
            fo = m_efield;
        end else begin
            if (m_slv) begin
                hn = m_h < m_hsw; vn = m_v < m_vsw;
            end else begin
                hn = (h == m_hp); vn = (v == m_vp);
            end
            bnd = vn && !m_vsprev;
            m_vsprev = vn;
            ok = !hn && !vn;
            lset = hn;
            fo = (f != m_fe);
        end
        e_valid = ok; e_data = px; e_ls = ok && m_lpend; e_fs = ok && m_fpend; e_fld = fo;
        if (bnd) m_fpend = 1; else if (ok) m_fpend = 0;
        if (lset) m_lpend = 1; else if (ok) m_lpend = 0;
        if (m_slv) begin
            if (m_h == m_htot - 1) begin
                m_h = 0;
                if (m_v == m_vtot - 1) m_v = 0; else m_v++;
            end else m_h++;
        end else begin
            m_h = 0; m_v = 0;
        end
        if (bnd) load_cfg();
    endtask

    task automatic px(input logic [IN_W-1:0] d, input bit h, input bit v, input bit f);
        logic pre;
        pre = m_edge ? 1'b0 : 1'b1;
        if (pclk != pre) begin
            pclk = pre; cmp(); cmp();
        end
        vdata = d; vhs = h; vvs = v; vfld = f;
        cmp(); cmp();
        pclk = ~pre;
        cmp();
        model_tick(d, h, v, f);
        cmp();
        e_valid = 0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        pclk = cfg_edge_rise ? 1'b0 : 1'b1;
        e_valid = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        load_cfg();
        m_h = 0; m_v = 0; m_seq = 0;
        m_vsprev = 0; m_fpend = 0; m_lpend = 0;
        m_active = 0; m_lastv = 0; m_efield = 0;
        @(negedge clk);
        chk("R10 pix_valid", 32'(pix_valid), 0);
        chk("R10 line_start", 32'(pix_line_start), 0);
        chk("R10 frame_start", 32'(pix_frame_start), 0);
        chk("R10 gen_hs", 32'(gen_hs), 32'(exp_ghs()));
        chk("R10 gen_vs", 32'(gen_vs), 32'(exp_gvs()));
    endtask

    function automatic logic [IN_W-1:0] on92(input logic [7:0] w);
        return {2'b10, w, 2'b11};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired (%s)", ph);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // discrete master: width 8 shift 2, line sync low, frame sync high
        do_reset();
        ph = "R4 R1 R5 R6 discrete";
        px(on92(8'h11), 1, 0, 0);
        px(on92(8'h22), 1, 1, 0);
        px(on92(8'h33), 1, 1, 0);
        px(on92(8'h44), 0, 0, 0);
        px(on92(8'hA5), 1, 0, 0);
        px(on92(8'h3C), 1, 0, 1);
        px(on92(8'h00), 0, 0, 1);
        px(on92(8'hF0), 1, 0, 1);
        px(on92(8'h0F), 0, 1, 1);

        // new settings requested mid-frame, applied at next frame sync
        ph = "R9 R2 R3 reload";
        cfg_width = 4'd6; cfg_shift = 4'd0; cfg_dat_pol = 0; cfg_edge_rise = 0;
        cfg_hs_pol = 1; cfg_vs_pol = 1; cfg_fld_even = 0;
        px(on92(8'h5A), 1, 0, 0);
        px(on92(8'h5A), 1, 1, 0);
        px(12'h0C3, 0, 1, 0);
        px(12'h0C3, 1, 0, 0);
        px(12'h0C3, 0, 0, 0);
        px(12'hFFF, 0, 0, 1);
        px(12'h555, 0, 0, 0);

        // embedded codes on lines 9:2, sync wires ignored
        cfg_width = 4'd8; cfg_shift = 4'd2; cfg_dat_pol = 1; cfg_edge_rise = 1;
        cfg_embedded = 1; cfg_slave = 0; cfg_hs_pol = 1; cfg_vs_pol = 1;
        do_reset();
        ph = "R7 embedded";
        foreach (seq_a[i]) px(on92(seq_a[i]), i[0], i[1], 0);

        // slave generator, overrides embedded
        cfg_slave = 1; cfg_embedded = 1; cfg_width = 4'd10; cfg_shift = 4'd0;
        cfg_hs_pol = 0; cfg_vs_pol = 1; cfg_htot = 12'd6; cfg_hsw = 12'd1;
        cfg_vtot = 11'd4; cfg_vsw = 11'd1;
        do_reset();
        ph = "R8 slave";
        for (int i = 0; i < 40; i++) px(IN_W'(i * 37), i[0], i[1], i[2]);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    logic [7:0] seq_a [0:35] = '{
        8'hFF, 8'h00, 8'h00, 8'hB0, 8'h10,
        8'hFF, 8'h00, 8'h00, 8'hA0, 8'h10,
        8'hFF, 8'h00, 8'h00, 8'h80, 8'h40, 8'h41, 8'h42,
        8'hFF, 8'h00, 8'h00, 8'h90, 8'h55,
        8'hFF, 8'h00, 8'h00, 8'hC0, 8'h77, 8'h00,
        8'hFF, 8'h66,
        8'hFF, 8'h00, 8'h00, 8'h80, 8'h12, 8'h34
    };

endmodule